// File: doc/BRIEF.md
# Optical Disc Mirror Detector

This block watches a stream of digitized RF envelope samples from an optical disc pickup and raises a one-bit mirror flag wherever the RF modulation collapses, as happens when the laser spot crosses the land between tracks. Each accepted sample updates two hold trackers. One follows the peak of the signal and releases slowly. The other follows the bottom and rises at a selectable speed. The gap between them is the envelope.

The envelope feeds a first-order running average. A fraction of that average, chosen by a two-bit sensitivity field, is the adaptive threshold. The mirror flag is high while the envelope is below that threshold. Servo logic reads the flag as a plain level.

Samples arrive on a valid/ready stream. The block never applies back-pressure in normal operation. `in_ready` is low while reset is applied and on the first edge after it, and high from then on. A sample is taken on every rising edge where `in_valid` and `in_ready` are both high. All internal state changes only on such an edge.

Top module: `disc_mirror_detect`

## Requirements
- R1: Synchronous reset clears the peak tracker and the average to 0, sets the bottom tracker to full scale (255 for 8-bit samples) and drives `mirror_o` low.
- R2: `in_ready` is low during reset and high from the first edge after reset is released. A sample is taken only on an edge where `in_valid` and `in_ready` are both high. Without such an edge, `mirror_o` and all tracker state stay unchanged.
- R3: On each taken sample, the peak tracker loads the sample if the sample is greater than its value. Otherwise it drops by 1, saturating at 0.
- R4: On each taken sample, the bottom tracker loads the sample if the sample is less than its value. Otherwise it rises by 1, 2, 4 or 8 for `bot_rate` = 0, 1, 2 or 3, saturating at full scale.
- R5: The envelope is the updated peak minus the updated bottom, or 0 when the bottom exceeds the peak.
- R6: The average holds 6 fraction bits. On each taken sample it adds (envelope*64 - average) shifted right arithmetically by 6. It never exceeds full scale * 64.
- R7: `mirror_o` is high exactly when envelope*512 < average*(4+`sens_sel`). This places the threshold at 4/8, 5/8, 6/8 or 7/8 of the average for `sens_sel` = 0 to 3. A zero average therefore never gives a high flag.
- R8: `mirror_o` reflects the sample taken on the preceding edge. It is computed from the updated trackers and the updated average.
- R9: `bot_rate` and `sens_sel` are sampled on the same edge as the sample they apply to. Changing them between samples affects only later samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready |
| in_sample | input | DW | Unsigned RF envelope sample |
| bot_rate | input | 2 | Bottom tracker rise speed select |
| sens_sel | input | 2 | Threshold fraction select |
| mirror_o | output | 1 | Mirror flag |

## Verification
On every cycle, the checker confirms the reset values and the ready behaviour. It also confirms that each tracker catches a sample beyond its value, that the flag holds between taken samples, that the average stays in range, and that a zero average never raises the flag. The decay and rise arithmetic, the saturation at both rails, the averaging and the four threshold fractions show only in the bench. There, a model written from the requirements runs every combination of speed and sensitivity through rail, alternating, collapsing and random sample patterns, and compares the flag after each sample.

// File: rtl/disc_mirror_pkg.sv
package disc_mirror_pkg;

  typedef enum logic [1:0] {
    RISE_X1 = 2'd0,
    RISE_X2 = 2'd1,
    RISE_X4 = 2'd2,
    RISE_X8 = 2'd3
  } rise_rate_e;

  typedef enum logic {
    TRACK_TOP    = 1'b1,
    TRACK_BOTTOM = 1'b0
  } track_dir_e;

  // Threshold numerator over eighths: 4,5,6,7
  function automatic logic [3:0] sens_weight(input logic [1:0] sel);
    return 4'd4 + {2'b00, sel};
  endfunction

endpackage

// File: rtl/mirror_hold_track.sv
module mirror_hold_track
  import disc_mirror_pkg::*;
#(
  parameter int         DW  = 8,
  parameter track_dir_e DIR = TRACK_TOP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] level,
  output logic [DW-1:0] level_nxt
);

  logic          catch_s;
  logic [DW-1:0] moved;
  logic [DW-1:0] rst_val;

  generate
    if (DIR == TRACK_TOP) begin : g_top
      // follows maxima, releases downward, floor at zero
      always_comb begin
        catch_s = sample > level;
        moved   = (level >= step) ? level - step : '0;
        rst_val = '0;
      end
    end else begin : g_bottom
      logic [DW:0] sum;
      // follows minima, releases upward, ceiling at full scale
      always_comb begin
        catch_s = sample < level;
        sum     = {1'b0, level} + {1'b0, step};
        moved   = sum[DW] ? '1 : sum[DW-1:0];
        rst_val = '1;
      end
    end
  endgenerate

  always_comb begin
    level_nxt = level;
    if (take) level_nxt = catch_s ? sample : moved;
  end

  always_ff @(posedge clk) begin
    if (rst) level <= rst_val;
    else     level <= level_nxt;
  end

endmodule

// File: rtl/mirror_env_avg.sv
module mirror_env_avg #(
  parameter int DW = 8,
  parameter int SH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [DW-1:0]    env_in,
  output logic [DW+SH-1:0] avg_q,
  output logic [DW+SH-1:0] avg_nxt
);

  localparam int AW = DW + SH;

  logic signed [AW+1:0] target;
  logic signed [AW+1:0] cur;
  logic signed [AW+1:0] diff;
  logic signed [AW+1:0] delta;
  logic signed [AW+1:0] sum;

  always_comb begin
    target  = $signed({2'b00, env_in, {SH{1'b0}}});
    cur     = $signed({2'b00, avg_q});
    diff    = target - cur;
    delta   = diff >>> SH;
    sum     = cur + delta;
    avg_nxt = take ? sum[AW-1:0] : avg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) avg_q <= '0;
    else     avg_q <= avg_nxt;
  end

endmodule

// File: rtl/disc_mirror_detect.sv
module disc_mirror_detect
  import disc_mirror_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AVG_SHIFT = 6,
  parameter int PK_DECAY  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_sample,
  input  logic [1:0]    bot_rate,
  input  logic [1:0]    sens_sel,
  output logic          mirror_o
);

  localparam int AW = DW + AVG_SHIFT;
  localparam int CW = AW + 3;

  logic          rdy_q;
  logic          take;
  logic [DW-1:0] pk_step;
  logic [DW-1:0] bt_step;
  logic [DW-1:0] pk_lvl, pk_nxt;
  logic [DW-1:0] bt_lvl, bt_nxt;
  logic [DW-1:0] env_nxt;
  logic [AW-1:0] avg_lvl, avg_nxt;
  logic [CW-1:0] cmp_lhs, cmp_rhs;
  rise_rate_e    rate_e;

  always_ff @(posedge clk) rdy_q <= !rst;

  assign in_ready = rdy_q;
  assign take     = in_valid & rdy_q;
  assign rate_e   = rise_rate_e'(bot_rate);
  assign pk_step  = DW'(PK_DECAY);
  assign bt_step  = DW'(1) << rate_e;

  mirror_hold_track #(.DW(DW), .DIR(TRACK_TOP)) u_peak (
    .clk(clk), .rst(rst), .take(take), .sample(in_sample),
    .step(pk_step), .level(pk_lvl), .level_nxt(pk_nxt)
  );

  mirror_hold_track #(.DW(DW), .DIR(TRACK_BOTTOM)) u_bottom (
    .clk(clk), .rst(rst), .take(take), .sample(in_sample),
    .step(bt_step), .level(bt_lvl), .level_nxt(bt_nxt)
  );

  assign env_nxt = (pk_nxt >= bt_nxt) ? pk_nxt - bt_nxt : '0;

  mirror_env_avg #(.DW(DW), .SH(AVG_SHIFT)) u_avg (
    .clk(clk), .rst(rst), .take(take), .env_in(env_nxt),
    .avg_q(avg_lvl), .avg_nxt(avg_nxt)
  );

  // envelope scaled by 8 * 2^AVG_SHIFT against average times eighths weight
  always_comb begin
    cmp_lhs = CW'(env_nxt) << (AVG_SHIFT + 3);
    cmp_rhs = CW'(avg_nxt) * CW'(sens_weight(sens_sel));
  end

  always_ff @(posedge clk) begin
    if (rst)       mirror_o <= 1'b0;
    else if (take) mirror_o <= cmp_lhs < cmp_rhs;
  end

endmodule

// File: rtl/disc_mirror_detect_chk.sv
module disc_mirror_detect_chk #(
  parameter int DW        = 8,
  parameter int AVG_SHIFT = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [DW-1:0]         in_sample,
  input logic                  mirror_o,
  input logic [DW-1:0]         pk_q,
  input logic [DW-1:0]         bt_q,
  input logic [DW+AVG_SHIFT-1:0] avg_q
);

  localparam int AW = DW + AVG_SHIFT;
  localparam logic [AW-1:0] AVG_MAX = {{DW{1'b1}}, {AVG_SHIFT{1'b0}}};

  logic acc;
  assign acc = in_valid && in_ready;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!mirror_o && pk_q == '0 && bt_q == '1 && avg_q == '0));

  p_not_ready_in_reset_r2: assert property (@(posedge clk)
    rst |=> !in_ready);

  p_ready_after_reset_r2: assert property (@(posedge clk)
    !rst |=> in_ready);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(mirror_o) && $stable(pk_q) && $stable(bt_q) && $stable(avg_q)));

  p_peak_catch_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && in_sample > pk_q) |=> pk_q == $past(in_sample));

  p_bottom_catch_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && in_sample < bt_q) |=> bt_q == $past(in_sample));

  p_avg_bound_r6: assert property (@(posedge clk) disable iff (rst)
    avg_q <= AVG_MAX);

  p_zero_avg_no_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (avg_q == '0) |-> !mirror_o);

endmodule

bind disc_mirror_detect disc_mirror_detect_chk #(.DW(DW), .AVG_SHIFT(AVG_SHIFT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_sample(in_sample), .mirror_o(mirror_o),
  .pk_q(pk_lvl), .bt_q(bt_lvl), .avg_q(avg_lvl)
);

// File: tb/test_disc_mirror_detect.sv
module test_disc_mirror_detect;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_sample;
  logic [1:0] bot_rate;
  logic [1:0] sens_sel;
  logic       mirror_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int m_pk, m_bt, m_avg, m_env;
  bit m_mir;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  disc_mirror_detect i_disc_mirror_detect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .bot_rate(bot_rate), .sens_sel(sens_sel),
    .mirror_o(mirror_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  task automatic model_reset();
    m_pk = 0; m_bt = 255; m_avg = 0; m_mir = 0;
  endtask

  // R3 R4 R5 R6 R7 model
  task automatic model_step(input int s, input int rate, input int sn);
    int d;
    if (s > m_pk) m_pk = s; else m_pk = (m_pk >= 1) ? m_pk - 1 : 0;
    if (s < m_bt) m_bt = s; else m_bt = (m_bt + (1 << rate) > 255) ? 255 : m_bt + (1 << rate);
    m_env = (m_pk >= m_bt) ? m_pk - m_bt : 0;
    d = m_env * 64 - m_avg;
    m_avg = m_avg + (d >>> 6);
    m_mir = (m_env * 512) < (m_avg * (4 + sn));
  endtask

  task automatic send(input int s, input int sn, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 8'(s);
    sens_sel  = 2'(sn);
    @(negedge clk);
    in_valid  = 1'b0;
    model_step(s, int'(bot_rate), sn);
    check(mirror_o == m_mir, tag, int'(mirror_o), int'(m_mir));
  endtask

  task automatic idle_gap(input int n);
    logic was;
    was = mirror_o;
    in_sample = 8'(rnd());
    repeat (n) @(negedge clk);
    check(mirror_o == was, "R2 flag held while idle", int'(mirror_o), int'(was));
  endtask

  task automatic run_cfg(input int rate, input int sn);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;       // must be ignored during reset (R2)
    in_sample = 8'd77;
    bot_rate = 2'(rate);
    sens_sel = 2'(sn);
    repeat (2) @(negedge clk);
    check(in_ready == 1'b0, "R2 ready low in reset", int'(in_ready), 0);
    check(mirror_o == 1'b0, "R1 flag low in reset", int'(mirror_o), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready after reset", int'(in_ready), 1);
    check(mirror_o == 1'b0, "R1 flag after reset", int'(mirror_o), 0);
    // R3 floor at zero and R4 ceiling at full scale
    repeat (3) send(0, sn, "R3 peak floor");
    repeat (4) send(255, sn, "R4 bottom ceiling");
    repeat (4) send(0, sn, "R3 R5 rail swing");
    // alternating strong modulation
    for (int i = 0; i < 150; i++) begin
      if (i[0]) send(30 + (rnd() & 15), sn, "R6 R7 modulated");
      else      send(200 + (rnd() & 15), sn, "R6 R7 modulated");
    end
    // collapse of modulation: flag must rise (R7, R8)
    for (int i = 0; i < 80; i++) begin
      send(110, sn, "R7 R8 collapse");
      if (i % 20 == 19) idle_gap(3);
    end
    // random samples with sensitivity changed per sample (R9)
    for (int i = 0; i < 120; i++) begin
      send(rnd(), rnd() & 3, "R9 per-sample select");
      if (i % 30 == 29) idle_gap(2);
    end
  endtask

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_sample = '0;
    bot_rate = '0;
    sens_sel = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R2 ready low at start", int'(in_ready), 0);
    check(mirror_o == 1'b0, "R1 flag low at start", int'(mirror_o), 0);
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 4; s++)
        run_cfg(r, s);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule